// File: doc/BRIEF.md
# Pin-Multiplexed General-Purpose I/O Port

This block is a port of bidirectional pins. Software chooses, pin by pin, who owns each pin. In peripheral mode, an on-chip peripheral drives the pad's output enable and output data and sees the pad's value directly. In register mode, software registers set the direction and the output value, and software reads the pad's value back through the data register. While a pin is in register mode, the input returned to the peripheral is held high.

A pull-up can be requested for each pin. The block withholds it from the pad whenever that pin is driving, whichever owner is driving it.

A single-cycle synchronous register port gives access to four registers:

| Address | Register |
|---------|----------|
| 0 | mode |
| 1 | direction |
| 2 | data |
| 3 | pull-up request |

Each register holds one bit per pin. Writes land on the clock edge that samples the write strobe. Reads are combinational. When a pin is in register mode and is an input, the data register read returns the pad value after it has passed through a two-flop synchroniser.

Top module: `gpx_port`

## Requirements
- R1: After reset, all four registers (address 0 mode, 1 direction, 2 data, 3 pull-up request) read 0, so every pin is in peripheral mode with no pull-up.
- R2: With `bus_wr` high, the register at `bus_addr` takes `bus_wdata` on that clock edge. Its value is readable on `bus_rdata` from that edge on, with no further cycle.
- R3: A pin whose mode bit is 0 (peripheral mode) drives `pad_oe` from `per_oe` and `pad_do` from `per_do`, combinationally.
- R4: A pin in peripheral mode passes `pad_in` to `per_di` combinationally, with no synchroniser delay.
- R5: A pin whose mode bit is 1 (register mode) drives `pad_oe` from its direction bit (1 = output) and `pad_do` from its data bit. Its `per_oe` and `per_do` have no effect on the pad.
- R6: A pin in register mode presents logic 1 on `per_di`, whatever the pad value.
- R7: `pad_pu` equals the pull-up request bit, except that it is 0 whenever the same pin's `pad_oe` is 1, in either mode.
- R8: Reading address 2 returns, for a pin in register mode with direction 0, the pad value as it stood two clock edges earlier (two-flop synchroniser).
- R9: Reading address 2 returns the stored data bit for every pin that is in peripheral mode or that is a register-mode output.
- R10: Mode, direction and pull-up settings act on each pin independently, so peripheral-mode and register-mode pins coexist in one port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | NPINS | Write data, one bit per pin |
| bus_rdata | output | NPINS | Combinational read data |
| per_oe | input | NPINS | Peripheral output enable per pin |
| per_do | input | NPINS | Peripheral output data per pin |
| per_di | output | NPINS | Input data returned to the peripheral |
| pad_oe | output | NPINS | Pad output enable |
| pad_do | output | NPINS | Pad output data |
| pad_pu | output | NPINS | Pad pull-up enable |
| pad_in | input | NPINS | Raw pad input value |

## Verification
The critical coincidence is a direction-register write landing on the same edge at which the pad input changes, on pins whose pull-up request is set. On that one edge, `pad_oe` must rise and `pad_pu` must drop together, and the data-register read must switch from synchronised pad values to stored bits. The bench provokes this by writing the direction register in the cycle where it alters `pad_in`. At the next falling edge, it compares all pad outputs and the read value against its register model. The synchroniser's two-edge latency is judged separately at each falling edge after a pad change.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_MODE = 2'd0,
        REG_DIR  = 2'd1,
        REG_DATA = 2'd2,
        REG_PULL = 2'd3
    } gpx_reg_e;

endpackage

// File: rtl/gpx_regfile.sv
module gpx_regfile
    import gpx_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NPINS-1:0]  wdata,
    output logic [NPINS-1:0]  mode_q,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  data_q,
    output logic [NPINS-1:0]  pull_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            dir_q  <= '0;
            data_q <= '0;
            pull_q <= '0;
        end else if (wr_en) begin
            unique case (gpx_reg_e'(addr))
                REG_MODE: mode_q <= wdata;
                REG_DIR:  dir_q  <= wdata;
                REG_DATA: data_q <= wdata;
                REG_PULL: pull_q <= wdata;
            endcase
        end
    end

    // R2: a write lands in the selected register on the strobe edge
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && gpx_reg_e'(addr) == REG_DIR) |=> (dir_q == $past(wdata)))
        else $error("p_write_lands_r2");

    // R2: no strobe, no change
    p_hold_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mode_q) && $stable(pull_q))
        else $error("p_hold_no_write_r2");

endmodule

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int NPINS  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] d,
    output logic [NPINS-1:0] q
);

    logic [NPINS-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];

    // cycles since reset, saturating, so $past never reaches back before reset
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (!rst_n)           age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    if (STAGES == 2) begin : g_chk2
        // R8: output is the input two edges back
        p_sync_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (age_q >= 2'd2) |-> (q == $past(d, 2)))
            else $error("p_sync_latency_r8");
    end

endmodule

// File: rtl/gpx_pin_mux.sv
module gpx_pin_mux (
    input  logic gpio_sel,
    input  logic dir_out,
    input  logic dat_bit,
    input  logic pull_req,
    input  logic per_oe,
    input  logic per_do,
    input  logic pad_in,
    output logic pad_oe,
    output logic pad_do,
    output logic pad_pu,
    output logic per_di
);

    logic drive;

    always_comb begin
        if (gpio_sel) begin
            drive  = dir_out;
            pad_do = dat_bit;
            per_di = 1'b1;
        end else begin
            drive  = per_oe;
            pad_do = per_do;
            per_di = pad_in;
        end
        pad_oe = drive;
        pad_pu = pull_req & ~drive;
    end

endmodule

// File: rtl/gpx_port.sv
module gpx_port
    import gpx_pkg::*;
#(
    parameter int NPINS       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  per_oe,
    input  logic [NPINS-1:0]  per_do,
    output logic [NPINS-1:0]  per_di,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_do,
    output logic [NPINS-1:0]  pad_pu,
    input  logic [NPINS-1:0]  pad_in
);

    logic [NPINS-1:0] mode_q, dir_q, data_q, pull_q;
    logic [NPINS-1:0] pad_sync;
    logic [NPINS-1:0] data_view;

    gpx_regfile #(.NPINS(NPINS)) regs_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .mode_q (mode_q),
        .dir_q  (dir_q),
        .data_q (data_q),
        .pull_q (pull_q)
    );

    gpx_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (pad_sync)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        gpx_pin_mux mux_i (
            .gpio_sel (mode_q[i]),
            .dir_out  (dir_q[i]),
            .dat_bit  (data_q[i]),
            .pull_req (pull_q[i]),
            .per_oe   (per_oe[i]),
            .per_do   (per_do[i]),
            .pad_in   (pad_in[i]),
            .pad_oe   (pad_oe[i]),
            .pad_do   (pad_do[i]),
            .pad_pu   (pad_pu[i]),
            .per_di   (per_di[i])
        );

        // register-mode inputs read the synchronised pad; all else the stored bit
        assign data_view[i] = (mode_q[i] && !dir_q[i]) ? pad_sync[i] : data_q[i];

        // R3
        p_periph_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !mode_q[i] |-> (pad_oe[i] == per_oe[i]) && (pad_do[i] == per_do[i]))
            else $error("p_periph_drive_r3");
        // R4
        p_periph_in_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !mode_q[i] |-> (per_di[i] == pad_in[i]))
            else $error("p_periph_in_r4");
        // R5
        p_reg_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
            mode_q[i] |-> (pad_oe[i] == dir_q[i]) && (pad_do[i] == data_q[i]))
            else $error("p_reg_drive_r5");
        // R6
        p_fb_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
            mode_q[i] |-> per_di[i])
            else $error("p_fb_high_r6");
        // R7
        p_pull_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
            pad_oe[i] |-> !pad_pu[i])
            else $error("p_pull_gated_r7");
        p_pull_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (!pad_oe[i] && pull_q[i]) |-> pad_pu[i])
            else $error("p_pull_follows_r7");
    end

    always_comb begin
        unique case (gpx_reg_e'(bus_addr))
            REG_MODE: bus_rdata = mode_q;
            REG_DIR:  bus_rdata = dir_q;
            REG_DATA: bus_rdata = data_view;
            REG_PULL: bus_rdata = pull_q;
        endcase
    end

    // R1: registers come out of reset cleared
    p_reset_clear_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (mode_q == '0) && (pull_q == '0) && (dir_q == '0))
        else $error("p_reset_clear_r1");

endmodule

// File: tb/gpx_port_tb_top.sv
module gpx_port_tb_top;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         bus_wr;
    logic [1:0]   bus_addr;
    logic [N-1:0] bus_wdata, bus_rdata;
    logic [N-1:0] per_oe, per_do, per_di;
    logic [N-1:0] pad_oe, pad_do, pad_pu, pad_in;

    always #5 clk = ~clk;

    gpx_port #(.NPINS(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .per_oe(per_oe), .per_do(per_do), .per_di(per_di),
        .pad_oe(pad_oe), .pad_do(pad_do), .pad_pu(pad_pu), .pad_in(pad_in)
    );

    typedef enum {K_RDATA, K_PADOE, K_PADDO, K_PADPU, K_PERDI} kind_e;
    typedef struct {
        kind_e        k;
        logic [N-1:0] exp;
        string        req;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // model of the registers, from the requirements
    logic [N-1:0] m_sel = '0, m_dir = '0, m_dat = '0, m_pu = '0;

    function automatic logic [N-1:0] e_oe();
        return (m_sel & m_dir) | (~m_sel & per_oe);
    endfunction
    function automatic logic [N-1:0] e_do();
        return (m_sel & m_dat) | (~m_sel & per_do);
    endfunction
    function automatic logic [N-1:0] e_pu();
        return m_pu & ~e_oe();
    endfunction
    function automatic logic [N-1:0] e_di();
        return m_sel | (~m_sel & pad_in);
    endfunction

    // monitor: pops and compares at each falling edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [N-1:0] act;
            it = q.pop_front();
            unique case (it.k)
                K_RDATA: act = bus_rdata;
                K_PADOE: act = pad_oe;
                K_PADDO: act = pad_do;
                K_PADPU: act = pad_pu;
                K_PERDI: act = per_di;
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s %s actual=%h expected=%h", it.req, it.k.name(), act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic settle();
        @(negedge clk); #1;
    endtask

    task automatic push(kind_e k, logic [N-1:0] e, string r);
        item_t it;
        it.k = k; it.exp = e; it.req = r;
        q.push_back(it);
    endtask

    task automatic wr(logic [1:0] a, logic [N-1:0] d);
        tick();
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
        unique case (a)
            2'd0: m_sel = d;
            2'd1: m_dir = d;
            2'd2: m_dat = d;
            2'd3: m_pu  = d;
        endcase
    endtask

    task automatic pads(string r);
        push(K_PADOE, e_oe(), r);
        push(K_PADDO, e_do(), r);
        push(K_PADPU, e_pu(), r);
        push(K_PERDI, e_di(), r);
        settle();
    endtask

    task automatic rd(logic [1:0] a, logic [N-1:0] e, string r);
        bus_addr = a;
        push(K_RDATA, e, r);
        settle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        per_oe = 8'hA5; per_do = 8'h3C; pad_in = 8'h00;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: all registers cleared
        for (int a = 0; a < 4; a++) rd(2'(a), 8'h00, "R1");
        pads("R1");

        // R3, R4: peripheral mode under several patterns
        for (int p = 0; p < 3; p++) begin
            per_oe = 8'h0F << p; per_do = 8'h96 ^ 8'(p * 37); pad_in = 8'h5A + 8'(p);
            #1;
            pads("R3/R4");
        end

        // R2: write lands on the strobe edge, read back at once
        wr(2'd3, 8'hFF);
        rd(2'd3, 8'hFF, "R2");
        // R7: pull-up gated by peripheral drive
        per_oe = 8'h33; #1;
        pads("R7");

        // R10, R5, R6: mixed ownership
        wr(2'd1, 8'hCC);
        wr(2'd2, 8'hAA);
        wr(2'd0, 8'hF0);
        rd(2'd0, 8'hF0, "R2");
        pads("R10");
        // R5: peripheral controls ignored on register-mode pins
        per_oe = 8'hFF; per_do = 8'h00; pad_in = 8'hFF; #1;
        pads("R5");
        per_oe = 8'h00; per_do = 8'hFF; pad_in = 8'h00; #1;
        pads("R6");

        // R9: register-mode outputs and peripheral-mode pins read stored bit
        wr(2'd1, 8'hFF);
        rd(2'd2, 8'hAA, "R9");

        // R8: synchroniser latency on register-mode inputs
        wr(2'd0, 8'hFF);
        wr(2'd1, 8'h0F);
        wr(2'd2, 8'h5A);
        rd(2'd2, 8'h0A, "R8");
        tick();
        pad_in = 8'h3C;
        rd(2'd2, 8'h0A, "R8");     // 0 edges since change
        rd(2'd2, 8'h0A, "R8");     // 1 edge
        rd(2'd2, 8'h3A, "R8");     // 2 edges

        // R7, R9: direction write and pad change on the same edge
        tick();
        bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 8'hFF; pad_in = 8'hC3;
        tick();
        bus_wr = 1'b0; m_dir = 8'hFF;
        bus_addr = 2'd2;
        push(K_RDATA, 8'h5A, "R9");
        pads("R7");

        // R1: second reset clears again
        rst_n = 1'b0; tick(); rst_n = 1'b1;
        m_sel = '0; m_dir = '0; m_dat = '0; m_pu = '0;
        rd(2'd0, 8'h00, "R1");
        rd(2'd3, 8'h00, "R1");

        repeat (2) settle();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule